// File: doc/BRIEF.md
# Shared-Pin Serial Configuration Loader

This block takes a 32-bit configuration word from an external controller over three wires: a chip enable, a serial clock and a single data pin. While the enable is high, each rising edge of the serial clock shifts one data bit in, most significant bit first. On the falling serial clock edge that follows the 32nd captured bit, the whole word is copied into the control register at once. From then on, the same data pin is no longer a configuration input. It is passed on as the live modulation bit stream, steered to an amplitude-keying output or a frequency-keying output depending on the modulation bit in the register.

All three inputs are sampled by the fast system clock through synchronizer chains, and the serial clock edges are found by comparing successive samples. A partial-progress flag rises on the falling edge after the second bit, which is the band-select bit. A completion flag rises when the register is loaded. Dropping the enable clears the bit count and both flags, so every enable cycle needs a fresh word. Serial clock edges that arrive after the register is loaded are ignored.

Top module: `cfg_serial_loader`

## Requirements
- R1: With enable high, each rising serial clock edge captures the data pin, most significant bit first; after 32 bits the concatenated field outputs {clock_only, band_hi, freq_word, sep_word, div4_sel, pwr_lvl, mod_ask, clk_out_en} equal the word sent.
- R2: The field outputs and cfg_done update only on the falling serial clock edge after the 32nd rising edge; while the serial clock is still high after that 32nd rising edge, cfg_done is 0 and the fields keep their old values.
- R3: part_done is 0 after one captured bit and after the second rising edge while the serial clock is still high, and becomes 1 on the falling edge after the second bit; it stays 1 while cfg_done is 1.
- R4: Field positions in the word: bit 31 clock_only, bit 30 band_hi, bits 29..15 freq_word (bit 15 its LSB), bits 14..7 sep_word, bit 6 div4_sel, bits 5..2 pwr_lvl, bit 1 mod_ask (1 selects amplitude keying, 0 frequency keying), bit 0 clk_out_en.
- R5: Before cfg_done, ask_data and fsk_data are both 0. After cfg_done, the data pin drives ask_data when mod_ask is 1 and fsk_data when mod_ask is 0; the other output stays 0.
- R6: Serial clock edges after cfg_done do not change any field output, and cfg_done stays 1.
- R7: Enable going low clears the bit count, part_done and cfg_done; a word started before the drop leaves no trace in the next word's capture.
- R8: After synchronous reset, cfg_done, part_done, ask_data, fsk_data and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Chip enable from the controller |
| sck_i | input | 1 | Serial clock from the controller |
| sdio_i | input | 1 | Shared configuration and modulation data pin |
| clock_only | output | 1 | Clock-only mode field |
| band_hi | output | 1 | Band select field |
| freq_word | output | 15 | Frequency value field |
| sep_word | output | 8 | Separation value field |
| div4_sel | output | 1 | Clock divide select field |
| pwr_lvl | output | 4 | Output power field |
| mod_ask | output | 1 | Modulation type field, 1 amplitude keying |
| clk_out_en | output | 1 | Clock output enable field |
| part_done | output | 1 | Band-select bit has been received |
| cfg_done | output | 1 | Full word loaded into the register |
| ask_data | output | 1 | Modulation stream when amplitude keying is selected |
| fsk_data | output | 1 | Modulation stream when frequency keying is selected |

## Verification
The main capture is driven with all-ones, all-zeros and the two alternating-bit words, which expose a bit-order reversal, an off-by-one shift and a stuck or swapped field, plus two realistic words with mixed field values that tell individual field boundaries apart. Each word is followed by a modulation phase in both pin levels, so a wrong keying select or an output leaking before completion shows up. Directed sequences stop the serial clock mid-edge around the second and 32nd bits to pin the falling-edge timing of both flags, add extra edges after completion, and abort a word halfway through an enable cycle.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int WORD_W   = 32;
  localparam int FREQ_W   = 15;
  localparam int SEP_W    = 8;
  localparam int PWR_W    = 4;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  // number of captured bits once the band-select bit is in
  localparam int BAND_CNT = 2;

  typedef struct packed {
    logic              clk_only;
    logic              band_hi;
    logic [FREQ_W-1:0] freq;
    logic [SEP_W-1:0]  sep;
    logic              div4;
    logic [PWR_W-1:0]  pwr;
    logic              ask_sel;
    logic              clk_en;
  } cfg_t;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift
  import cfgld_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_q,
  input  logic sck_q,
  input  logic din_q,
  output cfg_t cfg_q,
  output logic part_q,
  output logic done_q
);
  logic              sck_prev;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic              load;

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_q;
  end

  assign sck_rise = sck_q & ~sck_prev;
  assign sck_fall = ~sck_q & sck_prev;
  assign load     = en_q && sck_fall && (cnt == CNT_W'(WORD_W)) && !done_q;

  always_ff @(posedge clk) begin
    if (rst || !en_q) begin
      cnt    <= '0;
      part_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (sck_rise && (cnt < CNT_W'(WORD_W)))
        cnt <= cnt + CNT_W'(1);
      if (sck_fall && (cnt == CNT_W'(BAND_CNT)))
        part_q <= 1'b1;
      if (load)
        done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      sh <= '0;
    else if (en_q && sck_rise && (cnt < CNT_W'(WORD_W)))
      sh <= {sh[WORD_W-2:0], din_q};
  end

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (load) cfg_q <= cfg_t'(sh);
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgld_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              sck_i,
  input  logic              sdio_i,
  output logic              clock_only,
  output logic              band_hi,
  output logic [FREQ_W-1:0] freq_word,
  output logic [SEP_W-1:0]  sep_word,
  output logic              div4_sel,
  output logic [PWR_W-1:0]  pwr_lvl,
  output logic              mod_ask,
  output logic              clk_out_en,
  output logic              part_done,
  output logic              cfg_done,
  output logic              ask_data,
  output logic              fsk_data
);
  logic [2:0] raw, synced;
  logic       en_q, sck_q, din_q;
  cfg_t       cfg;

  assign raw = {en_i, sck_i, sdio_i};

  cfgld_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (synced)
  );

  assign {en_q, sck_q, din_q} = synced;

  cfgld_shift u_shift (
    .clk    (clk),
    .rst    (rst),
    .en_q   (en_q),
    .sck_q  (sck_q),
    .din_q  (din_q),
    .cfg_q  (cfg),
    .part_q (part_done),
    .done_q (cfg_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ask_data <= 1'b0;
      fsk_data <= 1'b0;
    end else begin
      ask_data <= cfg_done &  cfg.ask_sel & din_q;
      fsk_data <= cfg_done & ~cfg.ask_sel & din_q;
    end
  end

  assign clock_only = cfg.clk_only;
  assign band_hi    = cfg.band_hi;
  assign freq_word  = cfg.freq;
  assign sep_word   = cfg.sep;
  assign div4_sel   = cfg.div4;
  assign pwr_lvl    = cfg.pwr;
  assign mod_ask    = cfg.ask_sel;
  assign clk_out_en = cfg.clk_en;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        part_done,
  input logic        cfg_done,
  input logic        ask_data,
  input logic        fsk_data,
  input logic [31:0] cfg_word
);
  // R8
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!cfg_done && !part_done && !ask_data && !fsk_data));

  // R3
  flag_order_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> part_done);

  // R2
  done_after_part_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(part_done));

  // R6
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && $past(cfg_done)) |-> $stable(cfg_word));

  // R5
  mod_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ask_data || fsk_data) |-> $past(cfg_done));

  // R5
  mod_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ask_data && fsk_data));

  // R7
  clear_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(part_done) |-> !cfg_done);
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .part_done (part_done),
  .cfg_done  (cfg_done),
  .ask_data  (ask_data),
  .fsk_data  (fsk_data),
  .cfg_word  ({clock_only, band_hi, freq_word, sep_word, div4_sel,
               pwr_lvl, mod_ask, clk_out_en})
);

// File: tb/tb_cfg_serial_loader.sv
`timescale 1ns/1ps
module tb_cfg_serial_loader;
  localparam int HALF = 8;
  localparam int NV   = 6;
  localparam logic [31:0] VEC [0:NV-1] = '{
    32'hFFFF_FFFF,
    32'h0000_0000,
    32'hAAAA_AAAA,
    32'h5555_5555,
    {1'b0, 1'b1, 15'd14342, 8'd100, 1'b1, 4'd8, 1'b0, 1'b1},
    {1'b1, 1'b0, 15'd3730, 8'd1, 1'b0, 4'd15, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, sck_i = 1'b0, sdio_i = 1'b0;
  logic clock_only, band_hi, div4_sel, mod_ask, clk_out_en;
  logic [14:0] freq_word;
  logic [7:0]  sep_word;
  logic [3:0]  pwr_lvl;
  logic part_done, cfg_done, ask_data, fsk_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cfg_serial_loader dut (
    .clk(clk), .rst(rst), .en_i(en_i), .sck_i(sck_i), .sdio_i(sdio_i),
    .clock_only(clock_only), .band_hi(band_hi), .freq_word(freq_word),
    .sep_word(sep_word), .div4_sel(div4_sel), .pwr_lvl(pwr_lvl),
    .mod_ask(mod_ask), .clk_out_en(clk_out_en), .part_done(part_done),
    .cfg_done(cfg_done), .ask_data(ask_data), .fsk_data(fsk_data)
  );

  function automatic logic [31:0] fields();
    return {clock_only, band_hi, freq_word, sep_word, div4_sel,
            pwr_lvl, mod_ask, clk_out_en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_rise(logic d);
    sdio_i = d;
    wait_n(HALF);
    sck_i = 1'b1;
    wait_n(HALF);
  endtask

  task automatic sck_fall();
    sck_i = 1'b0;
    wait_n(HALF);
  endtask

  task automatic en_on();
    en_i = 1'b1;
    wait_n(HALF);
  endtask

  task automatic en_off();
    en_i = 1'b0; sck_i = 1'b0; sdio_i = 1'b0;
    wait_n(HALF);
  endtask

  task automatic send_word(logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      sck_rise(w[i]);
      sck_fall();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    // R8: reset state
    chk("R8 fields", fields(), 32'h0);
    chk("R8 flags", {28'h0, part_done, cfg_done, ask_data, fsk_data}, 32'h0);
    rst = 1'b0;
    wait_n(HALF);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] w;
      w = VEC[v];
      en_on();
      send_word(w);
      chk("R1 word", fields(), w);
      chk("R4 freq", {17'h0, freq_word}, {17'h0, w[29:15]});
      chk("R4 sep", {24'h0, sep_word}, {24'h0, w[14:7]});
      chk("R4 pwr", {28'h0, pwr_lvl}, {28'h0, w[5:2]});
      chk("R4 mode bits", {28'h0, clock_only, band_hi, div4_sel, mod_ask},
          {28'h0, w[31], w[30], w[6], w[1]});
      chk("R2 done", {31'h0, cfg_done}, 32'h1);
      chk("R3 part", {31'h0, part_done}, 32'h1);
      sdio_i = 1'b1; wait_n(HALF);
      chk("R5 pin high", {30'h0, ask_data, fsk_data}, {30'h0, w[1], ~w[1]});
      sdio_i = 1'b0; wait_n(HALF);
      chk("R5 pin low", {30'h0, ask_data, fsk_data}, 32'h0);
      send_word(~w);
      chk("R6 extra edges", fields(), w);
      chk("R6 done held", {31'h0, cfg_done}, 32'h1);
      en_off();
      chk("R7 flags cleared", {30'h0, part_done, cfg_done}, 32'h0);
    end

    // R3 / R2: edge-by-edge timing of the flags
    en_on();
    sck_rise(1'b1); sck_fall();
    chk("R3 after one bit", {31'h0, part_done}, 32'h0);
    sck_rise(1'b0);
    chk("R3 second bit sck high", {31'h0, part_done}, 32'h0);
    sck_fall();
    chk("R3 after band bit", {31'h0, part_done}, 32'h1);
    for (int i = 29; i >= 1; i--) begin
      sck_rise(1'b0); sck_fall();
    end
    chk("R2 after 31 bits", {31'h0, cfg_done}, 32'h0);
    sdio_i = 1'b1; wait_n(HALF);
    chk("R5 before done", {30'h0, ask_data, fsk_data}, 32'h0);
    sck_rise(1'b1);
    chk("R2 32nd bit sck high", {31'h0, cfg_done}, 32'h0);
    chk("R2 fields unchanged", fields(), VEC[NV-1]);
    sck_fall();
    chk("R2 loaded on fall", fields(), 32'h8000_0001);
    chk("R2 done on fall", {31'h0, cfg_done}, 32'h1);
    en_off();

    // R7: aborted word leaves no trace
    en_on();
    for (int i = 0; i < 10; i++) begin
      sck_rise(1'b1); sck_fall();
    end
    en_off();
    en_on();
    send_word(32'h1234_5678);
    chk("R7 fresh word", fields(), 32'h1234_5678);
    en_off();

    // R8: reset in the middle of operation
    en_on();
    send_word(32'hDEAD_BEEF);
    rst = 1'b1;
    wait_n(3);
    chk("R8 mid reset fields", fields(), 32'h0);
    chk("R8 mid reset flags", {30'h0, part_done, cfg_done}, 32'h0);
    rst = 1'b0;
    en_off();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule